// File: doc/BRIEF.md
# Differential PSK Symbol Demodulator

This block turns a stream of despread complex correlation samples, one per symbol, into hard bit decisions. Each strobed symbol is compared against the one before it. Two products are formed from the pair: the in-phase product Dot = I(k)·I(k-1) + Q(k)·Q(k-1) and the quadrature product Cross = Q(k)·I(k-1) − I(k)·Q(k-1). The decision depends only on their signs, so the absolute carrier phase never has to be known. In binary mode one bit is produced per symbol. In quaternary mode two bits are produced, half a symbol apart.

For conventional quaternary differential signalling, the phase differences sit on the product axes. An optional fixed −45° rotation of the current sample (I' = I + Q, Q' = Q − I, exact integer arithmetic with a √2 gain) moves these differences into the centres of the sign quadrants. Without the rotation, the block decides directly on signals whose differences already lie at odd multiples of 45°.

A burst-start flag, given together with a symbol strobe, marks that symbol as a new reference. No bits are produced for it. The first symbol after reset is treated in the same way. Results leave on a serial bit line and a two-bit parallel word, each framed by an active-low ready pulse one clock long.

Top module: `dpsk_symbol_demod`

## Requirements
- R1: While reset is held and after it is released, `data_rdy_n` is 1, `bit_out` is 0 and `pair_out` is 00 until the first decision.
- R2: Binary mode (`qpsk_mode`=0): each valid symbol gives one bit, 1 when Dot < 0 and 0 when Dot ≥ 0, on `bit_out`, with `pair_out` = {bit, 0}. It appears with a one-cycle low on `data_rdy_n` two clock edges after the edge that samples the strobe.
- R3: Quaternary mode with rotation (`qpsk_mode`=1, `rot_en`=1): the current sample is replaced by (I+Q, Q−I) before the products are formed. The dibit is {Dot<0, Cross≥0}, so phase differences of 0°, 90°, 180° and 270° give 00, 01, 11 and 10.
- R4: Quaternary mode without rotation (`rot_en`=0): the same dibit rule is applied to the unrotated products.
- R5: In quaternary mode, the first pulse (two edges after the strobe) loads `pair_out` with the dibit and puts its high bit on `bit_out`. Exactly HALF_SYM clocks later, a second pulse puts the low bit on `bit_out`, and `pair_out` is unchanged.
- R6: `data_rdy_n` is low for one clock per produced bit and high otherwise. `bit_out` and `pair_out` change only on the edges that start a low pulse.
- R7: A strobe with `burst_start`=1, or the first strobe after reset, produces no bits. That sample becomes the reference for the next symbol.
- R8: The products are exact for full-scale inputs, including −128 on both rails with rotation, so their signs are never corrupted by overflow.
- R9: `qpsk_mode` and `rot_en` are sampled with the strobe. A change to them after the strobe does not alter that symbol's decision or its number of bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baseband sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Symbol strobe, one clock per symbol |
| burst_start | input | 1 | With `sym_valid`: this symbol starts a burst |
| sym_i | input | SW | Signed in-phase correlation sample |
| sym_q | input | SW | Signed quadrature correlation sample |
| qpsk_mode | input | 1 | 0 binary decisions, 1 quaternary decisions |
| rot_en | input | 1 | Apply −45° pre-rotation in quaternary mode |
| bit_out | output | 1 | Serial decided bit |
| pair_out | output | 2 | Parallel dibit (binary: {bit,0}) |
| data_rdy_n | output | 1 | Active-low one-clock new-bit pulse |

## Verification
A corrupted reference register or a wrong product sign shows up as a wrong `bit_out` value on the very next ready pulse, two edges after the following strobe. A bad rotation shows as a wrong dibit on the first pulse of that symbol. A faulty half-symbol counter or pending flag moves or drops the second quaternary pulse, which a per-cycle comparison of `data_rdy_n` catches within HALF_SYM clocks. Burst-start handling errors appear as an extra or missing pulse on the symbol right after the flag.

// File: rtl/dpsk_pkg.sv
`timescale 1ns/1ps
package dpsk_pkg;

   typedef enum logic {
      MOD_BINARY = 1'b0,
      MOD_QUAD   = 1'b1
   } mod_e;

   typedef struct packed {
      logic dot_neg;
      logic cross_neg;
   } sign_pair_t;

   // Gray-ordered dibit: high bit is the dot sign, low bit the inverted cross sign
   function automatic logic [1:0] dibit_of(sign_pair_t s);
      return {s.dot_neg, ~s.cross_neg};
   endfunction

endpackage

// File: rtl/dpsk_capture.sv
`timescale 1ns/1ps
module dpsk_capture #(
   parameter int SW     = 8,
   parameter bit ROT_HW = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sym_valid,
   input  logic                 burst_start,
   input  logic signed [SW-1:0] sym_i,
   input  logic signed [SW-1:0] sym_q,
   input  dpsk_pkg::mod_e       mode_in,
   input  logic                 rot_en,
   output logic signed [SW:0]   cur_i,
   output logic signed [SW:0]   cur_q,
   output logic signed [SW-1:0] prev_i,
   output logic signed [SW-1:0] prev_q,
   output logic                 s1_vld,
   output dpsk_pkg::mod_e       s1_mode
);
   import dpsk_pkg::*;

   localparam int RW = SW + 1;

   logic signed [RW-1:0] ext_i, ext_q;
   logic signed [RW-1:0] nxt_i, nxt_q;
   logic signed [SW-1:0] ref_i, ref_q;
   logic                 have_ref;

   assign ext_i = {sym_i[SW-1], sym_i};
   assign ext_q = {sym_q[SW-1], sym_q};

   generate
      if (ROT_HW) begin : g_rot
         always_comb begin
            if (mode_in == MOD_QUAD && rot_en) begin
               nxt_i = ext_i + ext_q;
               nxt_q = ext_q - ext_i;
            end else begin
               nxt_i = ext_i;
               nxt_q = ext_q;
            end
         end
      end else begin : g_norot
         assign nxt_i = ext_i;
         assign nxt_q = ext_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_i    <= '0;
         cur_q    <= '0;
         prev_i   <= '0;
         prev_q   <= '0;
         ref_i    <= '0;
         ref_q    <= '0;
         have_ref <= 1'b0;
         s1_vld   <= 1'b0;
         s1_mode  <= MOD_BINARY;
      end else begin
         s1_vld <= sym_valid && !burst_start && have_ref;
         if (sym_valid) begin
            cur_i    <= nxt_i;
            cur_q    <= nxt_q;
            prev_i   <= ref_i;
            prev_q   <= ref_q;
            ref_i    <= sym_i;
            ref_q    <= sym_q;
            have_ref <= 1'b1;
            s1_mode  <= mode_in;
         end
      end
   end

   AST_REF_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |-> $past(sym_valid && !burst_start)); // R7

endmodule

// File: rtl/dpsk_products.sv
`timescale 1ns/1ps
module dpsk_products #(
   parameter int SW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [SW:0]   cur_i,
   input  logic signed [SW:0]   cur_q,
   input  logic signed [SW-1:0] prev_i,
   input  logic signed [SW-1:0] prev_q,
   input  logic                 s1_vld,
   input  dpsk_pkg::mod_e       s1_mode,
   output dpsk_pkg::sign_pair_t p_sign,
   output logic                 p_vld,
   output dpsk_pkg::mod_e       p_mode
);
   import dpsk_pkg::*;

   localparam int PW   = 2 * SW + 1;
   localparam int SUMW = PW + 1;

   logic signed [PW-1:0]   m_ii, m_qq, m_qi, m_iq;
   logic signed [SUMW-1:0] dot_v, cross_v;

   assign m_ii = PW'(cur_i) * PW'(prev_i);
   assign m_qq = PW'(cur_q) * PW'(prev_q);
   assign m_qi = PW'(cur_q) * PW'(prev_i);
   assign m_iq = PW'(cur_i) * PW'(prev_q);

   assign dot_v   = SUMW'(m_ii) + SUMW'(m_qq);
   assign cross_v = SUMW'(m_qi) - SUMW'(m_iq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_sign <= '0;
         p_vld  <= 1'b0;
         p_mode <= MOD_BINARY;
      end else begin
         p_vld <= s1_vld;
         if (s1_vld) begin
            p_sign.dot_neg   <= dot_v[SUMW-1];
            p_sign.cross_neg <= cross_v[SUMW-1];
            p_mode           <= s1_mode;
         end
      end
   end

   AST_ZERO_REF_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && prev_i == '0 && prev_q == '0) |=> (p_vld && !p_sign.dot_neg && !p_sign.cross_neg)); // R2

endmodule

// File: rtl/dpsk_decide.sv
`timescale 1ns/1ps
module dpsk_decide #(
   parameter int HALF_SYM = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 p_vld,
   input  dpsk_pkg::sign_pair_t p_sign,
   input  dpsk_pkg::mod_e       p_mode,
   output logic                 bit_out,
   output logic [1:0]           pair_out,
   output logic                 rdy_n
);
   import dpsk_pkg::*;

   localparam int CW = $clog2(HALF_SYM);
   localparam logic [CW-1:0] CNT_LOAD = CW'(HALF_SYM - 1);

   logic [1:0]    dibit;
   logic          pend_q;
   logic          lo_q;
   logic [CW-1:0] cnt_q;

   assign dibit = dibit_of(p_sign);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_out  <= 1'b0;
         pair_out <= 2'b00;
         rdy_n    <= 1'b1;
         pend_q   <= 1'b0;
         lo_q     <= 1'b0;
         cnt_q    <= '0;
      end else if (p_vld) begin
         rdy_n <= 1'b0;
         cnt_q <= CNT_LOAD;
         lo_q  <= dibit[0];
         if (p_mode == MOD_QUAD) begin
            bit_out  <= dibit[1];
            pair_out <= dibit;
            pend_q   <= 1'b1;
         end else begin
            bit_out  <= p_sign.dot_neg;
            pair_out <= {p_sign.dot_neg, 1'b0};
            pend_q   <= 1'b0;
         end
      end else if (pend_q) begin
         if (cnt_q == '0) begin
            bit_out <= lo_q;
            rdy_n   <= 1'b0;
            pend_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
            rdy_n <= 1'b1;
         end
      end else begin
         rdy_n <= 1'b1;
      end
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_n |-> ($stable(bit_out) && $stable(pair_out))); // R6

   AST_FIRST_OF_PAIR_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> !rdy_n); // R5

   AST_SECOND_BIT_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_q == '0 && !p_vld) |=> (!rdy_n && $stable(pair_out) && !pend_q)); // R5

endmodule

// File: rtl/dpsk_symbol_demod.sv
`timescale 1ns/1ps
module dpsk_symbol_demod #(
   parameter int SW       = 8,
   parameter int HALF_SYM = 4,
   parameter bit ROT_HW   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sym_valid,
   input  logic          burst_start,
   input  logic [SW-1:0] sym_i,
   input  logic [SW-1:0] sym_q,
   input  logic          qpsk_mode,
   input  logic          rot_en,
   output logic          bit_out,
   output logic [1:0]    pair_out,
   output logic          data_rdy_n
);
   import dpsk_pkg::*;

   generate
      if (SW < 2) begin : g_bad_sw
         $error("dpsk_symbol_demod: SW must be at least 2");
      end
      if (HALF_SYM < 2) begin : g_bad_half
         $error("dpsk_symbol_demod: HALF_SYM must be at least 2");
      end
   endgenerate

   logic signed [SW:0]   cur_i, cur_q;
   logic signed [SW-1:0] prev_i, prev_q;
   logic                 s1_vld, p_vld;
   mod_e                 s1_mode, p_mode, mode_in;
   sign_pair_t           p_sign;

   assign mode_in = qpsk_mode ? MOD_QUAD : MOD_BINARY;

   dpsk_capture #(.SW(SW), .ROT_HW(ROT_HW)) u_capture (
      .clk(clk), .rst_n(rst_n),
      .sym_valid(sym_valid), .burst_start(burst_start),
      .sym_i($signed(sym_i)), .sym_q($signed(sym_q)),
      .mode_in(mode_in), .rot_en(rot_en),
      .cur_i(cur_i), .cur_q(cur_q),
      .prev_i(prev_i), .prev_q(prev_q),
      .s1_vld(s1_vld), .s1_mode(s1_mode)
   );

   dpsk_products #(.SW(SW)) u_products (
      .clk(clk), .rst_n(rst_n),
      .cur_i(cur_i), .cur_q(cur_q),
      .prev_i(prev_i), .prev_q(prev_q),
      .s1_vld(s1_vld), .s1_mode(s1_mode),
      .p_sign(p_sign), .p_vld(p_vld), .p_mode(p_mode)
   );

   dpsk_decide #(.HALF_SYM(HALF_SYM)) u_decide (
      .clk(clk), .rst_n(rst_n),
      .p_vld(p_vld), .p_sign(p_sign), .p_mode(p_mode),
      .bit_out(bit_out), .pair_out(pair_out), .rdy_n(data_rdy_n)
   );

   AST_BURST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && burst_start) |=> ##1 !p_vld); // R7

endmodule

// File: tb/dpsk_symbol_demod_tb.sv
`timescale 1ns/1ps
module dpsk_symbol_demod_tb;
   localparam int SW   = 8;
   localparam int HALF = 4;
   localparam int GAP  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_valid = 1'b0, burst_start = 1'b0, qpsk_mode = 1'b0, rot_en = 1'b0;
   logic [SW-1:0] sym_i = '0, sym_q = '0;
   logic bit_out, data_rdy_n;
   logic [1:0] pair_out;

   int n_checks = 0, n_fail = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   dpsk_symbol_demod #(.SW(SW), .HALF_SYM(HALF), .ROT_HW(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .burst_start(burst_start),
      .sym_i(sym_i), .sym_q(sym_q), .qpsk_mode(qpsk_mode), .rot_en(rot_en),
      .bit_out(bit_out), .pair_out(pair_out), .data_rdy_n(data_rdy_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int  m_cyc = 0;
   bit  m_have = 0;
   int  m_pi = 0, m_pq = 0;
   bit  m_bit = 0, m_rdy = 1;
   bit [1:0] m_pair = 0;
   int  ev_at[$];
   bit  ev_b[$];
   bit [1:0] ev_p[$];
   bit  ev_sp[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_have = 0; m_bit = 0; m_rdy = 1; m_pair = 0;
         ev_at.delete(); ev_b.delete(); ev_p.delete(); ev_sp.delete();
      end else begin
         m_cyc++;
         m_rdy = 1;
         while (ev_at.size() > 0 && ev_at[0] == m_cyc) begin
            m_bit = ev_b[0];
            if (ev_sp[0]) m_pair = ev_p[0];
            m_rdy = 0;
            void'(ev_at.pop_front()); void'(ev_b.pop_front());
            void'(ev_p.pop_front()); void'(ev_sp.pop_front());
         end
         if (sym_valid) begin
            int ci, cq, dot, crs;
            bit dn, cn;
            ci = int'($signed(sym_i));
            cq = int'($signed(sym_q));
            if (!burst_start && m_have) begin
               if (qpsk_mode && rot_en) begin
                  int t;
                  t = ci + cq; cq = cq - ci; ci = t;
               end
               dot = ci * m_pi + cq * m_pq;
               crs = cq * m_pi - ci * m_pq;
               dn = (dot < 0);
               cn = (crs < 0);
               if (qpsk_mode) begin
                  ev_at.push_back(m_cyc + 2); ev_b.push_back(dn);  ev_p.push_back({dn, !cn}); ev_sp.push_back(1);
                  ev_at.push_back(m_cyc + 2 + HALF); ev_b.push_back(!cn); ev_p.push_back(2'b00); ev_sp.push_back(0);
               end else begin
                  ev_at.push_back(m_cyc + 2); ev_b.push_back(dn); ev_p.push_back({dn, 1'b0}); ev_sp.push_back(1);
               end
            end
            m_have = 1;
            m_pi = int'($signed(sym_i));
            m_pq = int'($signed(sym_q));
         end
      end
   end

   // per-cycle comparison and pulse bookkeeping at the ports
   int ncyc = 0, pulses = 0, last_pulse = -1, last_gap = 0;
   always @(negedge clk) begin
      ncyc++;
      chk("R6 data_rdy_n", int'(data_rdy_n), int'(m_rdy));
      chk({cur_req, " bit_out"}, int'(bit_out), int'(m_bit));
      chk({cur_req, " pair_out"}, int'(pair_out), int'(m_pair));
      if (!data_rdy_n) begin
         if (last_pulse >= 0) last_gap = ncyc - last_pulse;
         last_pulse = ncyc;
         pulses++;
      end
   end

   task automatic send(input int i, input int q, input bit bs, input bit qp, input bit rt);
      @(negedge clk);
      sym_valid = 1; burst_start = bs; qpsk_mode = qp; rot_en = rt;
      sym_i = 8'(i); sym_q = 8'(q);
      @(negedge clk);
      sym_valid = 0; burst_start = 0;
      repeat (GAP) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      int p0;
      repeat (4) @(negedge clk);
      // R1: reset values
      chk("R1 rdy", int'(data_rdy_n), 1);
      chk("R1 bit", int'(bit_out), 0);
      chk("R1 pair", int'(pair_out), 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk("R1 rdy after release", int'(data_rdy_n), 1);

      // R7: first symbol after reset gives nothing
      cur_req = "R7"; p0 = pulses;
      send(40, -30, 0, 0, 0);
      chk("R7 no pulse after reset", pulses - p0, 0);

      // R2: binary decisions on the dot sign
      cur_req = "R2"; p0 = pulses;
      send(50, 10, 0, 0, 0);   chk("R2 bit dot>0", int'(bit_out), 0); chk("R2 pair", int'(pair_out), 0);
      send(-60, -5, 0, 0, 0);  chk("R2 bit dot<0", int'(bit_out), 1); chk("R2 pair", int'(pair_out), 2);
      send(0, 0, 0, 0, 0);     chk("R2 bit dot=0", int'(bit_out), 0);
      send(30, -90, 0, 0, 0);  chk("R2 bit zero ref", int'(bit_out), 0);
      send(-30, 90, 0, 0, 0);  chk("R2 bit flip", int'(bit_out), 1);
      chk("R2 one pulse per symbol", pulses - p0, 5);

      // R7: burst start inside a stream
      cur_req = "R7"; p0 = pulses;
      send(10, 10, 1, 0, 0);
      chk("R7 burst symbol silent", pulses - p0, 0);
      send(-10, -10, 0, 0, 0);
      chk("R7 next uses new ref", int'(bit_out), 1);
      chk("R7 one pulse", pulses - p0, 1);

      // R3: quaternary with rotation
      cur_req = "R3";
      send(100, 0, 1, 1, 1);
      send(100, 0, 0, 1, 1);   chk("R3 0 deg", int'(pair_out), 0);
      chk("R5 half-symbol spacing", last_gap, HALF);
      send(-100, 0, 0, 1, 1);  chk("R3 180 deg", int'(pair_out), 3);
      send(0, 100, 0, 1, 1);   chk("R3 270 deg", int'(pair_out), 2);
      chk("R5 second bit is low bit", int'(bit_out), 0);
      send(0, -100, 0, 1, 1);  chk("R3 180 deg again", int'(pair_out), 3);
      p0 = pulses;
      send(100, 0, 0, 1, 1);   chk("R3 90 deg", int'(pair_out), 1);
      chk("R5 two pulses", pulses - p0, 2);

      // R4: quaternary without rotation
      cur_req = "R4";
      send(70, 70, 0, 1, 0);   chk("R4 45 deg", int'(pair_out), 1);
      send(-99, 0, 0, 1, 0);   chk("R4 135 deg", int'(pair_out), 3);

      // R8: full-scale inputs
      cur_req = "R8";
      send(-128, -128, 1, 1, 1);
      send(-128, -128, 0, 1, 1); chk("R8 rotated extreme", int'(pair_out), 0);
      send(127, 127, 0, 0, 0);   chk("R8 binary extreme", int'(bit_out), 1);
      send(-128, -128, 0, 0, 0); chk("R8 binary extreme 2", int'(bit_out), 1);

      // R9: mode change right after the strobe
      cur_req = "R9"; p0 = pulses;
      @(negedge clk);
      sym_valid = 1; qpsk_mode = 1; rot_en = 1; sym_i = 8'(127); sym_q = 8'(-128);
      @(negedge clk);
      sym_valid = 0; qpsk_mode = 0; rot_en = 0;
      repeat (GAP) @(negedge clk);
      chk("R9 mode held for symbol", pulses - p0, 2);

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule